// File: doc/BRIEF.md
# Output Compare Timer with Master Channel

This block is a four-channel output-compare timer. A 16-bit counter runs freely while the run bit is set. Each channel holds a 16-bit compare value. When the counter arrives at that value, an enabled channel flips its own port pin.

Channel 3 also acts as a master channel. When it fires, every pin selected by the master mask is loaded from the master data register. This load takes priority over any compare action from channels 0 to 2 in the same cycle. The master mask also turns its pins into outputs. It does this through the output-enable logic only, so the stored direction register is never changed.

All settings are held in registers on a simple synchronous register bus:

- A write takes effect on the clock edge where `bus_we` is high.
- Reads are combinational from `bus_addr`.

The register bus is a control path with no streaming data, so it has no valid/ready handshake and applies no back-pressure. Register map:

| Address | Register |
|---|---|
| 0 | control (bit 0 = run) |
| 1 | counter, read-only |
| 2 | compare enables |
| 3 | direction |
| 4 | master mask |
| 5 | master data |
| 6 | port data |
| 8 to 11 | compare values for channels 0 to 3 |

Other addresses read as zero.

Top module: `octmr_top`

## Requirements
- R1: After reset the counter, every register, `pin_out` and `pin_oe` are zero.
- R2: With control bit 0 set, the counter adds one on every clock and wraps from 0xFFFF to 0x0000. With the bit clear, the counter holds. The counter reads at address 1, and bus writes to that address are ignored.
- R3: A channel whose compare-enable bit (address 2, bit n for channel n) is set toggles port bit n one clock after the counter arrives at its compare value. A channel with a clear enable bit leaves its pin alone.
- R4: A compare fires only in the cycle after the counter has advanced onto the value. A counter that is stopped on a compare value produces no further actions.
- R5: When channel 3 fires with its enable bit set, each port bit whose master-mask bit is set is loaded from the same bit of the master data register.
- R6: For a pin selected by the master mask, the channel 3 load wins over that pin's own compare toggle in the same cycle.
- R7: A port bit whose master-mask bit is clear is not touched by the master load. It keeps its value or follows its own channel.
- R8: `pin_oe[n]` equals direction bit n OR (compare-enable bit n AND master-mask bit n). Writing the mask never changes the direction register read back at address 3.
- R9: The master mask and master data registers can be written and read at any time. Only bits 3 to 0 are stored, and bits 15 to 4 read as zero.
- R10: A bus write to address 6 sets `pin_out` from the next clock, and address 6 reads back the port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_out | output | 4 | Port data driven to the pins |
| pin_oe | output | 4 | Per-pin output enable |

## Verification
The bench puts channel 3 and channels 0 and 1 on the same compare value, with a mask that covers some pins and not others. A design that let the toggle beat the master load, or that loaded unmasked pins, leaves a different port pattern.

It parks a stopped counter on an enabled compare value. A design that tests only for equality would toggle that pin on every clock.

It runs the counter through 0xFFFF and counts the exact number of increments, which catches a missed wrap or an off-by-one step. It also writes the mask while the direction bits are set, which exposes a design that folds the mask into the stored direction register.

// File: rtl/octmr_pkg.sv
package octmr_pkg;
  localparam int BUS_AW = 4;
  localparam int BUS_DW = 16;
  localparam int TMR_W  = 16;
  localparam int NUM_CH = 4;

  localparam logic [BUS_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [BUS_AW-1:0] A_COUNT = 4'd1;
  localparam logic [BUS_AW-1:0] A_OCEN  = 4'd2;
  localparam logic [BUS_AW-1:0] A_DIR   = 4'd3;
  localparam logic [BUS_AW-1:0] A_MMASK = 4'd4;
  localparam logic [BUS_AW-1:0] A_MDATA = 4'd5;
  localparam logic [BUS_AW-1:0] A_PORT  = 4'd6;
  localparam logic [BUS_AW-1:0] A_CMP0  = 4'd8;
endpackage

// File: rtl/octmr_counter.sv
module octmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         adv
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      adv <= 1'b0;
    end else begin
      adv <= run;
      if (run) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt == $past(cnt) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)); // R2
endmodule

// File: rtl/octmr_cmp_bank.sv
module octmr_cmp_bank #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cnt,
  input  logic           adv,
  input  logic [N*W-1:0] cmp_flat,
  output logic [N-1:0]   hit
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [W-1:0] cmp_v;
    assign cmp_v  = cmp_flat[g*W +: W];
    assign hit[g] = adv && (cnt == cmp_v);

    AST_HIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> (!hit[g] || !$stable(cmp_v))); // R4
  end
endmodule

// File: rtl/octmr_regs.sv
module octmr_regs
  import octmr_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [W-1:0]   cnt,
  input  logic [N-1:0]   port_q,
  output logic           run,
  output logic [N-1:0]   oc_en,
  output logic [N-1:0]   dir,
  output logic [N-1:0]   mmask,
  output logic [N-1:0]   mdata,
  output logic [N*W-1:0] cmp_flat,
  output logic           port_we
);
  assign port_we = we && (addr == A_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      oc_en <= '0;
      dir   <= '0;
      mmask <= '0;
      mdata <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL:  run   <= wdata[0];
        A_OCEN:  oc_en <= wdata[N-1:0];
        A_DIR:   dir   <= wdata[N-1:0];
        A_MMASK: mmask <= wdata[N-1:0];
        A_MDATA: mdata <= wdata[N-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) cmp_flat[g*W +: W] <= '0;
      else if (we && (addr == A_CMP0 + AW'(g))) cmp_flat[g*W +: W] <= wdata[W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[0]     = run;
      A_COUNT: rdata[W-1:0] = cnt;
      A_OCEN:  rdata[N-1:0] = oc_en;
      A_DIR:   rdata[N-1:0] = dir;
      A_MMASK: rdata[N-1:0] = mmask;
      A_MDATA: rdata[N-1:0] = mdata;
      A_PORT:  rdata[N-1:0] = port_q;
      default: begin
        for (int k = 0; k < N; k++)
          if (addr == A_CMP0 + AW'(k)) rdata[W-1:0] = cmp_flat[k*W +: W];
      end
    endcase
  end

  AST_DIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MMASK) |=> $stable(dir)); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MMASK || addr == A_MDATA) |-> (rdata[DW-1:N] == '0)); // R9
endmodule

// File: rtl/octmr_port.sv
module octmr_port #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] oc_en,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] mmask,
  input  logic [N-1:0] mdata,
  input  logic         sw_we,
  input  logic [N-1:0] sw_data,
  output logic [N-1:0] port_q,
  output logic [N-1:0] port_oe
);
  localparam int MST = N - 1;

  logic master_fire;
  assign master_fire = hit[MST] && oc_en[MST];

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic take_master, take_own;
    assign take_master = master_fire && mmask[g];
    assign take_own    = hit[g] && oc_en[g];

    always_ff @(posedge clk) begin
      if (!rst_n)           port_q[g] <= 1'b0;
      else if (take_master) port_q[g] <= mdata[g];
      else if (take_own)    port_q[g] <= ~port_q[g];
      else if (sw_we)       port_q[g] <= sw_data[g];
    end

    assign port_oe[g] = dir[g] | (oc_en[g] & mmask[g]);

    AST_MASTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (master_fire && mmask[g]) |=> (port_q[g] == $past(mdata[g]))); // R6
    AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(master_fire && mmask[g]) && !(hit[g] && oc_en[g]) && !sw_we) |=> $stable(port_q[g])); // R7
  end
endmodule

// File: rtl/octmr_top.sv
module octmr_top
  import octmr_pkg::*;
#(
  parameter int W  = TMR_W,
  parameter int N  = NUM_CH,
  parameter int AW = BUS_AW,
  parameter int DW = BUS_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe
);
  logic [W-1:0]   cnt;
  logic           adv, run, port_we;
  logic [N-1:0]   oc_en, dir, mmask, mdata, hit;
  logic [N*W-1:0] cmp_flat;

  octmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .adv(adv)
  );

  octmr_cmp_bank #(.W(W), .N(N)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .adv(adv),
    .cmp_flat(cmp_flat), .hit(hit)
  );

  octmr_regs #(.W(W), .N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .port_q(pin_out),
    .run(run), .oc_en(oc_en), .dir(dir), .mmask(mmask), .mdata(mdata),
    .cmp_flat(cmp_flat), .port_we(port_we)
  );

  octmr_port #(.N(N)) u_port (
    .clk(clk), .rst_n(rst_n), .hit(hit), .oc_en(oc_en), .dir(dir),
    .mmask(mmask), .mdata(mdata), .sw_we(port_we),
    .sw_data(bus_wdata[N-1:0]), .port_q(pin_out), .port_oe(pin_oe)
  );
endmodule

// File: tb/sim_octmr_top.sv
module sim_octmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pin_out, pin_oe;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  octmr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // run the counter: increments = n + 2
  task automatic run_for(input int n);
    wr(4'd0, 16'd1);
    repeat (n) @(negedge clk);
    wr(4'd0, 16'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    rd(4'd1, v); chk("R1 counter", v, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    rd(4'd4, v); chk("R1 mask", v, 0);
  endtask

  task automatic t_count;
    logic [15:0] c, c2;
    int d;
    rd(4'd1, c);
    run_for(10);
    rd(4'd1, c2); chk("R2 step count", c2, 16'(c + 16'd12));
    wr(4'd1, 16'h1234);
    rd(4'd1, c); chk("R2 counter write ignored", c, c2);
    d = (32'h10002 - int'(c)) & 32'hFFFF;
    if (d < 2) d += 65536;
    run_for(d - 2);
    rd(4'd1, c); chk("R2 wrap", c, 16'd2);
  endtask

  task automatic t_toggle;
    logic [15:0] c;
    wr(4'd6, 16'h0); wr(4'd4, 16'h0);
    rd(4'd1, c);
    wr(4'd8, c + 16'd4); wr(4'd9, c + 16'd4);
    wr(4'd2, 16'h1);
    run_for(20);
    chk("R3 enabled toggles, disabled holds", pin_out, 4'b0001);
  endtask

  task automatic t_parked;
    logic [15:0] c;
    wr(4'd6, 16'h0);
    rd(4'd1, c);
    wr(4'd8, c); wr(4'd2, 16'h1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R4 parked counter no action", pin_out, 4'b0000);
    end
  endtask

  task automatic t_master;
    logic [15:0] c;
    wr(4'd2, 16'h0); wr(4'd6, 16'h0);
    rd(4'd1, c);
    wr(4'd8, c + 16'd4); wr(4'd9, c + 16'd4);
    wr(4'd10, c + 16'd100); wr(4'd11, c + 16'd4);
    wr(4'd4, 16'b0101); wr(4'd5, 16'b0100);
    wr(4'd2, 16'hF);
    run_for(20);
    chk("R5 masked pin2 loaded from data", pin_out[2], 1'b1);
    chk("R6 master beats pin0 toggle", pin_out[0], 1'b0);
    chk("R7 unmasked pin1 follows own channel", pin_out[1], 1'b1);
    chk("R7 unmasked pin3 own toggle", pin_out[3], 1'b1);
  endtask

  task automatic t_oe;
    logic [15:0] v;
    wr(4'd3, 16'h1); wr(4'd2, 16'b0110); wr(4'd4, 16'b0011);
    @(negedge clk);
    chk("R8 oe combine", pin_oe, 4'b0011);
    rd(4'd3, v); chk("R8 dir unchanged by mask", v, 16'h1);
    wr(4'd4, 16'h0);
    @(negedge clk);
    chk("R8 oe mask cleared", pin_oe, 4'b0001);
  endtask

  task automatic t_rsv;
    logic [15:0] v;
    wr(4'd4, 16'hFFFF); rd(4'd4, v); chk("R9 mask reserved zero", v, 16'h000F);
    wr(4'd5, 16'hABCD); rd(4'd5, v); chk("R9 data reserved zero", v, 16'h000D);
  endtask

  task automatic t_port;
    logic [15:0] v;
    wr(4'd2, 16'h0);
    wr(4'd6, 16'h000A);
    @(negedge clk);
    chk("R10 port write drives pins", pin_out, 4'hA);
    rd(4'd6, v); chk("R10 port readback", v, 16'h000A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset; t_count; t_toggle; t_parked; t_master; t_oe; t_rsv; t_port;
      end
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule